// File: doc/BRIEF.md
# Scaled-Step Platform Timer with Per-Hart Compare

This block keeps a 64-bit free-running time value for a group of harts and raises one timer interrupt per hart. One unit of the time value always stands for 10 ns, which is a fixed 100 MHz timebase. The counter is advanced by a single-cycle `tick` enable that comes from a slower update clock running between 10 MHz and 100 MHz. On every tick the counter adds `STEP`, the timebase divided by the update rate. A 25 MHz update source therefore uses `STEP = 4`. `STEP` is checked at elaboration and must lie between 1 and 10.

Each hart has its own 64-bit compare register. That hart's interrupt line is a registered level that is high while the time value is at or above its compare value. Software reaches the time and compare registers through a simple word-addressed bus. Each 64-bit register appears as two 32-bit words, low half at the even word and high half at the next word. The map is: word 0 is time low, word 1 is time high, and words `2+2h` and `3+2h` are hart `h`'s compare low and high halves. Reads return data one cycle after the request.

Top module: `plat_timer`

## Requirements
- R1: After reset the time value is 0, every compare register reads 0xFFFFFFFF in both halves, and all interrupt lines are low.
- R2: On each cycle with `tick` high and no write to the time register, the time value grows by exactly `STEP`.
- R3: On cycles with `tick` low and no write to the time register, the time value holds.
- R4: A read request returns, one cycle later, `rsp_valid` high and the addressed word: word 0 is time bits 31:0, word 1 is time bits 63:32, word 2+2h is compare h bits 31:0, and word 3+2h is compare h bits 63:32.
- R5: A write to one half of a 64-bit register changes only that half.
- R6: When a write to the time register and a tick fall in the same cycle, the written half takes the written data, the other half keeps its value, and no step is added in that cycle.
- R7: A hart's interrupt is high one cycle after its compare value is less than or equal to the time value, compared as unsigned 64-bit numbers, equality included.
- R8: A hart's interrupt falls one cycle after software writes a compare value larger than the time value.
- R9: Each hart's compare register and interrupt are independent: writing one hart's compare does not change another hart's compare or interrupt.
- R10: A read of a word outside the map returns 0, and a write to such a word changes no register.
- R11: A step that crosses bit 31 of the time value carries into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle update enable from the slower update clock |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
A software write to the time register and an update tick can land in the same cycle. The bench forces this by raising `tick` and a write to the time low word on the same clock edge. It then reads both halves back: the low word must equal the written data exactly, with no `STEP` added, and the high word must be unchanged. A second overlap is a compare write against a time value that is already past. The bench checks that the interrupt level follows the new compare value on the cycle after the write.

// File: rtl/plat_timer_pkg.sv
`timescale 1ns/1ps
package plat_timer_pkg;
  localparam int unsigned WORD_W         = 32;
  localparam int unsigned TIME_W         = 64;
  localparam int unsigned TIMEBASE_MHZ   = 100;
  localparam int unsigned MIN_UPDATE_MHZ = 10;
  localparam int unsigned MAX_STEP       = TIMEBASE_MHZ / MIN_UPDATE_MHZ;

  typedef logic [TIME_W-1:0] time_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/timer_counter.sv
`timescale 1ns/1ps
module timer_counter
  import plat_timer_pkg::*;
#(
  parameter int unsigned STEP = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  word_t wdata,
  output time_t count_q
);
  localparam time_t STEP_T = TIME_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (wr_lo || wr_hi) begin
      // a software write replaces the step for this cycle
      if (wr_lo) count_q[WORD_W-1:0]      <= wdata;
      if (wr_hi) count_q[TIME_W-1:WORD_W] <= wdata;
    end else if (tick) begin
      count_q <= count_q + STEP_T;
    end
  end

  // R2
  step_add_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(tick) && !$past(wr_lo || wr_hi))
      |-> (count_q == $past(count_q) + STEP_T));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(tick) && !$past(wr_lo || wr_hi))
      |-> $stable(count_q));

  // R6
  wr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(wr_lo) && !$past(wr_hi))
      |-> (count_q[WORD_W-1:0] == $past(wdata) &&
           count_q[TIME_W-1:WORD_W] == $past(count_q[TIME_W-1:WORD_W])));
endmodule

// File: rtl/timer_cmp_bank.sv
`timescale 1ns/1ps
module timer_cmp_bank
  import plat_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  time_t                           time_i,
  input  logic [NUM_HARTS-1:0]            wr_lo,
  input  logic [NUM_HARTS-1:0]            wr_hi,
  input  word_t                           wdata,
  output logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_q,
  output logic [NUM_HARTS-1:0]            irq_q
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_q[h] <= '1;
        irq_q[h] <= 1'b0;
      end else begin
        if (wr_lo[h]) cmp_q[h][WORD_W-1:0]      <= wdata;
        if (wr_hi[h]) cmp_q[h][TIME_W-1:WORD_W] <= wdata;
        irq_q[h] <= (time_i >= cmp_q[h]);
      end
    end

    // R1
    cmp_rst_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cmp_q[h] == '1 && !irq_q[h]));

    // R9
    cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$past(wr_lo[h] || wr_hi[h])) |-> $stable(cmp_q[h]));

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (irq_q[h] == ($past(time_i) >= $past(cmp_q[h]))));
  end
endmodule

// File: rtl/timer_regbus.sv
`timescale 1ns/1ps
module timer_regbus
  import plat_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic [ADDR_W-1:0]                req_addr,
  input  time_t                            time_i,
  input  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_i,
  output logic                             time_wr_lo,
  output logic                             time_wr_hi,
  output logic [NUM_HARTS-1:0]             cmp_wr_lo,
  output logic [NUM_HARTS-1:0]             cmp_wr_hi,
  output logic                             rsp_valid,
  output word_t                            rsp_rdata
);
  localparam int unsigned NUM_WORDS = 2 + 2 * NUM_HARTS;

  if (NUM_WORDS > (1 << ADDR_W)) begin : g_bad_addr_w
    initial $fatal(1, "address width too small for the register map");
  end

  logic                 hit_tlo, hit_thi;
  logic [NUM_HARTS-1:0] hit_clo, hit_chi;
  word_t                rd_next;
  logic                 do_wr, do_rd;

  assign do_wr = req_valid && req_write;
  assign do_rd = req_valid && !req_write;

  always_comb begin
    hit_tlo = (req_addr == ADDR_W'(0));
    hit_thi = (req_addr == ADDR_W'(1));
    hit_clo = '0;
    hit_chi = '0;
    rd_next = '0;
    if (hit_tlo) rd_next = time_i[WORD_W-1:0];
    if (hit_thi) rd_next = time_i[TIME_W-1:WORD_W];
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (req_addr == ADDR_W'(2 + 2 * h)) begin
        hit_clo[h] = 1'b1;
        rd_next    = cmp_i[h][WORD_W-1:0];
      end
      if (req_addr == ADDR_W'(3 + 2 * h)) begin
        hit_chi[h] = 1'b1;
        rd_next    = cmp_i[h][TIME_W-1:WORD_W];
      end
    end
  end

  assign time_wr_lo = do_wr && hit_tlo;
  assign time_wr_hi = do_wr && hit_thi;
  assign cmp_wr_lo  = hit_clo & {NUM_HARTS{do_wr}};
  assign cmp_wr_hi  = hit_chi & {NUM_HARTS{do_wr}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      rsp_rdata <= do_rd ? rd_next : '0;
    end
  end

  // R4
  rsp_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rsp_valid == $past(req_valid && !req_write)));

  // R10
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({time_wr_lo, time_wr_hi, cmp_wr_lo, cmp_wr_hi}));
endmodule

// File: rtl/plat_timer.sv
`timescale 1ns/1ps
module plat_timer
  import plat_timer_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 2,
  parameter int unsigned STEP      = 4,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_HARTS-1:0] irq
);
  if (STEP < 1 || STEP > MAX_STEP) begin : g_bad_step
    initial $fatal(1, "STEP must keep the update rate within 10..100 MHz");
  end

  time_t                            count_q;
  logic [NUM_HARTS-1:0][TIME_W-1:0] cmp_q;
  logic                             time_wr_lo, time_wr_hi;
  logic [NUM_HARTS-1:0]             cmp_wr_lo, cmp_wr_hi;

  timer_regbus #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .time_i     (count_q),
    .cmp_i      (cmp_q),
    .time_wr_lo (time_wr_lo),
    .time_wr_hi (time_wr_hi),
    .cmp_wr_lo  (cmp_wr_lo),
    .cmp_wr_hi  (cmp_wr_hi),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  timer_counter #(.STEP(STEP)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr_lo   (time_wr_lo),
    .wr_hi   (time_wr_hi),
    .wdata   (req_wdata),
    .count_q (count_q)
  );

  timer_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .time_i (count_q),
    .wr_lo  (cmp_wr_lo),
    .wr_hi  (cmp_wr_hi),
    .wdata  (req_wdata),
    .cmp_q  (cmp_q),
    .irq_q  (irq)
  );
endmodule

// File: tb/plat_timer_bench.sv
`timescale 1ns/1ps
module plat_timer_bench;
  localparam int unsigned NH   = 2;
  localparam int unsigned STEP = 4;
  localparam int unsigned AW   = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NH-1:0] irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  plat_timer #(.NUM_HARTS(NH), .STEP(STEP), .ADDR_W(AW)) u_plat_timer (
    .clk(clk), .rst(rst), .tick(tick),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq(irq)
  );

  // monitor: pops the scoreboard when read data comes back
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected response: actual=%h expected=none", rsp_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk_irq(input int h, input logic e, input string t);
    checks++;
    if (irq[h] !== e) begin
      errors++;
      $display("FAIL %s: irq[%0d] actual=%b expected=%b", t, h, irq[h], e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(0, 1'b0, "R1 irq0 reset");
    chk_irq(1, 1'b0, "R1 irq1 reset");
    bus_read(0, 32'h0, "R1 time lo");
    bus_read(1, 32'h0, "R1 time hi");
    for (int w = 2; w < 6; w++) bus_read(w, 32'hFFFF_FFFF, "R1 compare word");

    // R4 map and readback, R2 step, R3 hold
    bus_write(0, 32'h10);
    bus_write(1, 32'h0);
    bus_read(0, 32'h10, "R4 time lo readback");
    run_ticks(3);
    bus_read(0, 32'h10 + 3 * STEP, "R2 three steps");
    repeat (5) @(negedge clk);
    bus_read(0, 32'h10 + 3 * STEP, "R3 hold without tick");

    // R5 half write
    bus_write(1, 32'h5);
    bus_read(0, 32'h10 + 3 * STEP, "R5 lo untouched");
    bus_read(1, 32'h5, "R5 hi written");

    // R11 carry into high half
    bus_write(0, 32'hFFFF_FFFC);
    bus_write(1, 32'h0);
    run_ticks(1);
    bus_read(0, 32'h0, "R11 carry lo");
    bus_read(1, 32'h1, "R11 carry hi");

    // R6 write and tick in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(0); req_wdata = 32'h55;
    tick = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
    bus_read(0, 32'h55, "R6 write wins lo");
    bus_read(1, 32'h1, "R6 hi kept");
    run_ticks(1);
    bus_read(0, 32'h55 + STEP, "R2 step after collision");

    // R7 equality, R9 independence, R8 drop
    bus_write(1, 32'h0);
    bus_write(0, 32'd100);
    bus_write(2, 32'd104);
    bus_write(3, 32'h0);
    @(negedge clk);
    chk_irq(0, 1'b0, "R7 below compare");
    run_ticks(1);
    @(negedge clk);
    chk_irq(0, 1'b1, "R7 equal compare");
    chk_irq(1, 1'b0, "R9 other hart quiet");
    bus_write(2, 32'd200);
    @(negedge clk);
    chk_irq(0, 1'b0, "R8 drop after larger compare");
    bus_read(2, 32'd200, "R4 compare0 lo");
    bus_read(3, 32'h0, "R4 compare0 hi");
    bus_read(4, 32'hFFFF_FFFF, "R9 compare1 untouched");

    // R7 unsigned compare with top bit set
    bus_write(1, 32'h8000_0000);
    bus_write(4, 32'h0);
    bus_write(5, 32'h7FFF_FFFF);
    @(negedge clk);
    chk_irq(1, 1'b1, "R7 unsigned compare");
    bus_write(5, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_irq(1, 1'b0, "R8 drop hart1");
    chk_irq(0, 1'b1, "R9 hart0 unaffected");

    // R10 unmapped word
    bus_read(63, 32'h0, "R10 unmapped read");
    bus_write(63, 32'h1234);
    bus_read(0, 32'd104, "R10 time lo unchanged");
    bus_read(2, 32'd200, "R10 compare unchanged");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4 missing responses: actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule